// File: doc/BRIEF.md
# Programmable PRBS Generator with Error Insertion

This block produces a serial pseudorandom test stream from a feedback shift register of up to 32 stages. A single 32-bit tap mask does two jobs. Its set bits choose the feedback positions, and its most significant set bit fixes the register length L. Any pattern of period 2^L-1 from L=1 to L=32 can therefore be built without a separate length field. A 32-bit seed word is copied into the register on request, so a known sequence can be replayed.

Several options act on the serial output. Zero suppression stops long runs of zeros, as required for the 2^20-1 quasi-random stream. A polarity control inverts the whole stream. Bit errors can be inserted one at a time on command, or at a steady decade rate. A clock enable lets a free-running line clock carry the stream only in selected time slots. While the enable is low, the output keeps the last bit sent.

Top module: `prbs_err_gen`

## Requirements
- R1: While `rst_n` is low, `dout` is 0, every register stage is 1 and no error is pending.
- R2: The feedback bit is the XOR of the stages selected by `tap_mask`. With a primitive two-tap mask such as 0x5 (L=3), 0x9, 0x12, 0x41 or 0x108 (L=9), the output repeats every 2^L-1 bits and holds 2^(L-1) ones per period.
- R3: On the clock edge where `load` is high and was low at the previous edge, the register takes `seed`, whether or not `clk_en` is high.
- R4: On each enabled edge, `dout` takes stage L-1 and the register shifts toward the top. After a load, the first L output bits are therefore seed[L-1] down to seed[0].
- R5: While `clk_en` is low, the register and `dout` hold their values.
- R6: When `inv_en` is 1, every output bit is complemented.
- R7: When `zsup_en` is 1 and L is at least 15, an output bit is forced to 1 if the 14 stages below it are all 0. For L=20 and seed 0x00001, the first 20 bits are then 1 five times, 0 fourteen times, then 1. Without the option they are 0 nineteen times, then 1.
- R8: A rising edge on `err_single`, seen at one clock edge, flips exactly one output bit: the bit sent at the next enabled edge.
- R9: A pending error is never applied to a bit that zero suppression forces. It waits for the first unforced bit. In the R7 setup with one error pending, the first 20 bits become 1 six times, 0 thirteen times, then 1.
- R10: `rate_code` k from 1 to 7 flips one bit in every 10^k enabled bits. The first flip falls on the first enabled bit after the code leaves 0. Code 0 inserts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Advances the pattern by one bit when high |
| tap_mask | input | 32 | Feedback taps; the highest set bit gives the length |
| seed | input | 32 | Value copied into the register on a load |
| load | input | 1 | Rising edge loads `seed` |
| zsup_en | input | 1 | Enables the 14-zero suppression rule |
| inv_en | input | 1 | Complements the output stream |
| err_single | input | 1 | Rising edge inserts one bit error |
| rate_code | input | 3 | Error rate: 0 none, k gives one error per 10^k bits |
| dout | output | 1 | Serial pattern output, registered |

## Verification
Each enabled edge registers one new output bit, so `dout` is read one time unit after the edge that produced it. A load occupies one edge, and the first seed bit appears on the first enabled edge after it. A single-error request is captured on one edge and shows up as the bit sent at the next enabled edge. Rate errors land on the very first enabled bit and then on every 10^k-th bit. The checks compare whole windows bit by bit against error-free reference runs or hand-derived words, so a bit arriving one edge early or late shows up as a miscompare.

// File: rtl/prbs_err_gen.sv
module prbs_err_gen #(
  parameter int W   = 32,
  parameter int RUN = 14,
  parameter int RW  = 3,
  parameter int CW  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic [W-1:0]  tap_mask,
  input  logic [W-1:0]  seed,
  input  logic          load,
  input  logic          zsup_en,
  input  logic          inv_en,
  input  logic          err_single,
  input  logic [RW-1:0] rate_code,
  output logic          dout
);
  localparam int NCODE = (1 << RW) - 1;

  logic [W-1:0]  sr, top, la;
  logic [CW-1:0] cnt;
  logic          load_q, single_q, err_pend;
  logic          raw, fb, zs_ok, force_one, fire, apply, ld_edge, single_edge;

  always_comb begin
    top = '0;
    for (int i = 0; i < W; i++)
      if (tap_mask[i]) begin
        top    = '0;
        top[i] = 1'b1;
      end
  end

  assign la          = (top - 1'b1) & ~((top >> RUN) - 1'b1);
  assign zs_ok       = |(top >> RUN);
  assign raw         = |(sr & top);
  assign fb          = ^(sr & tap_mask);
  assign force_one   = zsup_en & zs_ok & ~raw & ~|(sr & la);
  assign fire        = clk_en & (rate_code != '0) & (cnt == '0);
  assign apply       = clk_en & (err_pend | fire) & ~force_one;
  assign ld_edge     = load & ~load_q;
  assign single_edge = err_single & ~single_q;

  function automatic logic [CW-1:0] reload(input logic [RW-1:0] code);
    logic [CW-1:0] p;
    p = 1;
    for (int i = 0; i < NCODE; i++)
      if (i < int'(code)) p = p * 10;
    return p - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '1;
      dout     <= 1'b0;
      load_q   <= 1'b0;
      single_q <= 1'b0;
      err_pend <= 1'b0;
      cnt      <= '0;
    end else begin
      load_q   <= load;
      single_q <= err_single;
      if (ld_edge)     sr <= seed;
      else if (clk_en) sr <= {sr[W-2:0], fb};
      if (clk_en) dout <= raw ^ force_one ^ apply ^ inv_en;
      err_pend <= single_edge | ((err_pend | fire) & ~apply);
      if (rate_code == '0) cnt <= '0;
      else if (clk_en)     cnt <= (cnt == '0) ? reload(rate_code) : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/prbs_err_gen_chk.sv
module prbs_err_gen_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_en,
  input logic [W-1:0] seed,
  input logic         inv_en,
  input logic         dout,
  input logic [W-1:0] sr,
  input logic         ld_edge,
  input logic         force_one,
  input logic         err_pend
);
  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_edge |=> sr == $past(seed));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !ld_edge |=> sr[W-1:1] == $past(sr[W-2:0]));

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(dout));

  // R7
  forced_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && force_one |=> dout == !$past(inv_en));

  // R9
  defer_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && err_pend && force_one |=> err_pend);
endmodule

bind prbs_err_gen prbs_err_gen_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .seed(seed), .inv_en(inv_en),
  .dout(dout), .sr(sr), .ld_edge(ld_edge), .force_one(force_one),
  .err_pend(err_pend)
);

// File: tb/prbs_err_gen_test.sv
module prbs_err_gen_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, load = 1'b0;
  logic        zsup_en = 1'b0, inv_en = 1'b0, err_single = 1'b0;
  logic [31:0] tap_mask = 32'h5, seed = '1;
  logic [2:0]  rate_code = '0;
  logic        dout;
  int          n_vec = 0, n_bad = 0;
  logic        ref_bits [0:2999];
  logic        per_bits [0:511];

  localparam logic [63:0] VECS [5] = '{
    {32'h0000_0005, 32'd3}, {32'h0000_0009, 32'd4}, {32'h0000_0012, 32'd5},
    {32'h0000_0041, 32'd7}, {32'h0000_0108, 32'd9}
  };

  prbs_err_gen uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tap_mask(tap_mask), .seed(seed),
    .load(load), .zsup_en(zsup_en), .inv_en(inv_en), .err_single(err_single),
    .rate_code(rate_code), .dout(dout)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_seed(input logic [31:0] s);
    clk_en = 1'b0;
    seed = s;
    load = 1'b1;
    step();
    load = 1'b0;
    step();
  endtask

  task automatic grab20(output logic [19:0] w);
    w = '0;
    for (int i = 0; i < 20; i++) begin
      step();
      w = {w[18:0], dout};
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] w;
    int          ones, mism, pos;
    step(); step();
    chk("R1 reset dout", dout, 0);
    rst_n = 1'b1;

    // R2 vector table: maximal-length period and balance
    for (int v = 0; v < 5; v++) begin
      int per, len;
      tap_mask = VECS[v][63:32];
      len = int'(VECS[v][31:0]);
      per = (1 << len) - 1;
      load_seed('1);
      clk_en = 1'b1;
      ones = 0;
      for (int i = 0; i < per; i++) begin
        step();
        per_bits[i] = dout;
        ones += int'(dout);
      end
      mism = 0;
      for (int i = 0; i < per; i++) begin
        step();
        if (dout != per_bits[i]) mism++;
      end
      chk("R2 ones per period", ones, 1 << (len - 1));
      chk("R2 period repeat", mism, 0);
    end

    // R3 R4 R5: seed order with a gap in the enable
    tap_mask = 32'h6000;
    load_seed(32'h5A3C);
    mism = 0;
    clk_en = 1'b1;
    for (int i = 0; i < 15; i++) begin
      if (i == 5) begin
        logic last;
        last = dout;
        clk_en = 1'b0;
        for (int j = 0; j < 6; j++) begin
          step();
          chk("R5 hold during gap", dout, last);
        end
        clk_en = 1'b1;
      end
      step();
      if (dout != seed[14-i]) mism++;
    end
    chk("R3 R4 seed bits emitted top first", mism, 0);

    // R6 inversion
    inv_en = 1'b1;
    load_seed(32'h5A3C);
    clk_en = 1'b1;
    mism = 0;
    for (int i = 0; i < 15; i++) begin
      step();
      if (dout != !seed[14-i]) mism++;
    end
    chk("R6 inverted seed bits", mism, 0);
    inv_en = 1'b0;

    // R7 zero suppression
    tap_mask = 32'h8_0004;
    load_seed(32'h1);
    clk_en = 1'b1;
    grab20(w);
    chk("R7 plain long zero run", w, 20'h00001);
    zsup_en = 1'b1;
    load_seed(32'h1);
    clk_en = 1'b1;
    grab20(w);
    chk("R7 suppressed run", w, 20'hF8001);

    // R9 error deferred past forced bits
    load_seed(32'h1);
    err_single = 1'b1;
    step();
    err_single = 1'b0;
    step();
    clk_en = 1'b1;
    grab20(w);
    chk("R9 deferred error word", w, 20'hFC001);
    zsup_en = 1'b0;

    // reference run for R8 and R10
    tap_mask = 32'h108;
    load_seed('1);
    clk_en = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      step();
      ref_bits[i] = dout;
    end

    // R8 single error
    load_seed('1);
    clk_en = 1'b1;
    mism = 0;
    pos = -1;
    for (int i = 0; i < 30; i++) begin
      step();
      if (dout != ref_bits[i]) begin
        mism++;
        pos = i;
      end
      if (i == 4) err_single = 1'b1;
      if (i == 5) err_single = 1'b0;
    end
    chk("R8 single error count", mism, 1);
    chk("R8 single error position", pos, 6);

    // R10 rate codes 0..3
    for (int c = 0; c < 4; c++) begin
      int exp_n;
      rate_code = '0;
      load_seed('1);
      rate_code = 3'(c);
      step();
      clk_en = 1'b1;
      mism = 0;
      pos = 0;
      for (int i = 0; i < 3000; i++) begin
        step();
        if (dout != ref_bits[i]) begin
          mism++;
          if (c != 0 && (i % (10 ** c)) != 0) pos++;
        end
      end
      exp_n = (c == 0) ? 0 : 3000 / (10 ** c);
      chk("R10 error count for rate code", mism, exp_n);
      chk("R10 error spacing", pos, 0);
    end
    rate_code = '0;

    // R1 reset again mid-stream
    rst_n = 1'b0;
    step();
    chk("R1 reset clears dout", dout, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule